// File: doc/BRIEF.md
# Serial Byte Receiver with Ready/Valid Output

The block turns an asynchronous, idle-high serial line into whole bytes. It synchronises the line into the local clock domain and treats a high-to-low change as the start of a frame. It then times each bit by counting system clock cycles. Two parameters set that count: the clock rate in MHz and the line rate in bits per second. Each of the eight data bits is taken at the centre of its bit slot. The first data bit becomes the least significant bit of the byte.

After the last data bit the receiver waits only half of the stop bit. It then offers the byte on a valid/ready pair and holds both the byte and the valid flag until the consumer takes it. Because the stop wait is short, the receiver is back in its idle state well before the stop bit ends. A start bit that follows the stop bit directly is therefore still caught. While a byte is waiting to be taken, activity on the line is not looked at.

Top module: `uart_byte_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 8'h00. The reset is asynchronous, so it takes effect even in the middle of a frame.
- R2: A line held high with no high-to-low change produces no byte: `out_valid` stays 0.
- R3: The bit period is BIT_CYC = CLK_MHZ*1000000/BAUD cycles, and HALF = BIT_CYC/2. Count clock edges from the first rising edge that samples the line low, calling that edge 0. `out_valid` rises after edge 2 + 9*BIT_CYC + HALF, which allows two cycles for synchronisation, a full start bit, eight data bits and half a stop bit.
- R4: Each frame carries exactly eight data bits, least significant bit first. Every byte value from 8'h00 to 8'hFF is presented unchanged on `out_data`.
- R5: Each data bit is sampled HALF cycles into its synchronised bit slot. Line values in the first two cycles and the last two cycles of a data bit therefore have no effect on the received byte.
- R6: A frame whose start bit follows the previous frame's one-bit-long stop bit directly is received correctly, as is the previous frame.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. A frame that arrives on the line during this time is ignored and produces no later byte.
- R8: On a rising clock edge where `out_valid` and `out_ready` are both 1, the byte is consumed: `out_valid` is 0 on the next cycle, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| out_data | output | 8 | Received byte, stable while out_valid is high |
| out_valid | output | 1 | A received byte is on out_data |
| out_ready | input | 1 | The consumer takes the byte on a cycle where out_valid is also high |

## Verification
The hold and release properties take for granted that `out_ready` changes only between clock edges and is not tied to the serial line. The stimulus drives `out_ready` away from the edges and changes it only while no frame is in flight. The bit-timing checks assume that the serial line keeps exactly BIT_CYC cycles per bit. The stimulus meets this by generating every bit from the same clock. The only deliberate disturbance is confined to the two cycles at each end of a data bit, well clear of the centre sample point.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_HAND  = 3'd4
   } rx_state_t;

   // clock cycles per serial bit
   function automatic int unsigned bit_cycles(input int unsigned mhz, input int unsigned baud);
      return (mhz * 1000000) / baud;
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic line_s,
   output logic fall_p
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   // line idles high, so the chain resets to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign line_s = chain_q[STAGES-1];
   assign fall_p = prev_q & ~chain_q[STAGES-1];

   // a falling edge lasts one cycle only
   assert_fall_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      fall_p |=> !fall_p);

endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
   parameter int unsigned BIT_CYC = 434
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic mid_hit,
   output logic end_hit,
   output logic half_end
);

   localparam int unsigned HALF = BIT_CYC / 2;
   localparam int unsigned CW   = $clog2(BIT_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || clear || end_hit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mid_hit  = (cnt_q == CW'(HALF));
   assign end_hit  = (cnt_q == CW'(BIT_CYC - 1));
   assign half_end = (cnt_q == CW'(HALF - 1));

   assert_cnt_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(BIT_CYC - 1));

endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sample,
   input  logic             bit_end,
   input  logic             bit_in,
   output logic [WIDTH-1:0] data,
   output logic             last_bit
);

   localparam int unsigned IW = $clog2(WIDTH);

   logic [IW-1:0]    idx_q;
   logic [WIDTH-1:0] data_q;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("uart_rx_shifter: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (start) begin
         idx_q <= '0;
      end else if (bit_end) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   // earliest bit ends up in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (sample) begin
         data_q <= {bit_in, data_q[WIDTH-1:1]};
      end
   end

   assign data     = data_q;
   assign last_bit = (idx_q == IW'(WIDTH - 1));

endmodule

// File: rtl/uart_byte_rx.sv
module uart_byte_rx
   import uart_rx_pkg::*;
#(
   parameter int unsigned CLK_MHZ = 50,
   parameter int unsigned BAUD    = 115200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_line,
   output logic [7:0] out_data,
   output logic       out_valid,
   input  logic       out_ready
);

   localparam int unsigned BIT_CYC   = bit_cycles(CLK_MHZ, BAUD);
   localparam int unsigned DATA_BITS = 8;
   localparam int unsigned SYNC_LEN  = 2;

   generate
      if (BIT_CYC < 4) begin : g_bad_rate
         $error("uart_byte_rx: clock too slow for the chosen baud rate");
      end
   endgenerate

   rx_state_t state_q, state_d;
   logic line_s, fall_p;
   logic mid_hit, end_hit, half_end;
   logic last_bit;
   logic run, clear, sample, bit_end, start;

   uart_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (rx_line),
      .line_s (line_s),
      .fall_p (fall_p)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RX_IDLE:  if (fall_p)              state_d = RX_START;
         RX_START: if (end_hit)             state_d = RX_DATA;
         RX_DATA:  if (end_hit && last_bit) state_d = RX_STOP;
         RX_STOP:  if (half_end)            state_d = RX_HAND;
         RX_HAND:  if (out_ready)           state_d = RX_IDLE;
         default:                           state_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RX_IDLE;
      else        state_q <= state_d;
   end

   assign run     = (state_q == RX_START) || (state_q == RX_DATA) || (state_q == RX_STOP);
   assign clear   = (state_d != state_q);
   assign sample  = (state_q == RX_DATA) && mid_hit;
   assign bit_end = (state_q == RX_DATA) && end_hit;
   assign start   = (state_q == RX_IDLE) && fall_p;

   uart_rx_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .clear    (clear),
      .mid_hit  (mid_hit),
      .end_hit  (end_hit),
      .half_end (half_end)
   );

   uart_rx_shifter #(.WIDTH(DATA_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .sample   (sample),
      .bit_end  (bit_end),
      .bit_in   (line_s),
      .data     (out_data),
      .last_bit (last_bit)
   );

   assign out_valid = (state_q == RX_HAND);

   assert_hold_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_release_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> !out_valid);

endmodule

// File: tb/uart_byte_rx_tb_top.sv
`timescale 1ns/1ps
module uart_byte_rx_tb_top;

   localparam int unsigned CLK_MHZ = 1;
   localparam int unsigned BAUD    = 100000;
   localparam int B = (CLK_MHZ * 1000000) / BAUD;
   localparam int H = B / 2;
   localparam int LAT = 2 + 9 * B + H;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b1;

   int tests = 0;
   int fails = 0;
   int got_n = 0;
   logic [7:0] got_hist [0:1023];

   always #2.5 clk = ~clk;

   uart_byte_rx #(.CLK_MHZ(CLK_MHZ), .BAUD(BAUD)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_line   (rx_line),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready)
   );

   // record handshakes, sampled well before the next rising edge
   always begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
         got_hist[got_n % 1024] = out_data;
         got_n = got_n + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input bit glitch);
      rx_line = 1'b0;
      repeat (B) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         for (int c = 0; c < B; c++) begin
            rx_line = (glitch && (c < 2 || c >= B - 2)) ? ~b[i] : b[i];
            @(negedge clk);
         end
      end
      rx_line = 1'b1;
      repeat (B) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(out_valid), 0);
      chk("R1 data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(out_valid), 0);
      chk("R1 data after reset", int'(out_data), 0);

      // R2: idle line
      n0 = got_n;
      repeat (300) @(negedge clk);
      chk("R2 no byte on idle line", got_n - n0, 0);
      chk("R2 valid low on idle line", int'(out_valid), 0);

      // R3 latency, R8 release
      fork
         send_frame(8'hA5, 1'b0);
         begin
            repeat (LAT) @(negedge clk);
            chk("R3 valid not yet high", int'(out_valid), 0);
            @(negedge clk);
            chk("R3 valid high on time", int'(out_valid), 1);
            chk("R3 data on time", int'(out_data), 8'hA5);
            @(negedge clk);
            chk("R8 valid drops after handshake", int'(out_valid), 0);
         end
      join
      repeat (4) @(negedge clk);

      // R4 exhaustive byte sweep
      for (int v = 0; v < 256; v++) begin
         n0 = got_n;
         send_frame(v[7:0], 1'b0);
         repeat (4) @(negedge clk);
         chk("R4 one byte per frame", got_n - n0, 1);
         chk("R4 byte value", int'(got_hist[(got_n - 1) % 1024]), v);
      end

      // R5 edges of data bits disturbed
      for (int v = 0; v < 16; v++) begin
         logic [7:0] bv;
         bv = 8'(v * 17 + 3);
         n0 = got_n;
         send_frame(bv, 1'b1);
         repeat (4) @(negedge clk);
         chk("R5 disturbed frame count", got_n - n0, 1);
         chk("R5 centre sampled value", int'(got_hist[(got_n - 1) % 1024]), int'(bv));
      end

      // R6 back-to-back frames
      for (int p = 0; p < 3; p++) begin
         logic [7:0] b1, b2;
         b1 = 8'(8'h5A + p * 8'h31);
         b2 = ~b1;
         n0 = got_n;
         send_frame(b1, 1'b0);
         send_frame(b2, 1'b0);
         repeat (4) @(negedge clk);
         chk("R6 both frames taken", got_n - n0, 2);
         chk("R6 first byte", int'(got_hist[n0 % 1024]), int'(b1));
         chk("R6 second byte", int'(got_hist[(n0 + 1) % 1024]), int'(b2));
      end

      // R7 hold while not ready, line ignored
      @(negedge clk);
      #1 out_ready = 1'b0;
      n0 = got_n;
      send_frame(8'h3C, 1'b0);
      repeat (50) @(negedge clk);
      chk("R7 valid held", int'(out_valid), 1);
      chk("R7 data held", int'(out_data), 8'h3C);
      send_frame(8'hC3, 1'b0);
      repeat (5) @(negedge clk);
      chk("R7 valid still held", int'(out_valid), 1);
      chk("R7 data not overwritten", int'(out_data), 8'h3C);
      #1 out_ready = 1'b1;
      @(negedge clk);
      chk("R8 valid drops after late ready", int'(out_valid), 0);
      repeat (200) @(negedge clk);
      chk("R7 ignored frame gave no byte", got_n - n0, 1);
      chk("R7 held byte delivered", int'(got_hist[n0 % 1024]), 8'h3C);

      // R8 next frame after consumption
      n0 = got_n;
      send_frame(8'h81, 1'b0);
      repeat (4) @(negedge clk);
      chk("R8 next frame count", got_n - n0, 1);
      chk("R8 next frame value", int'(got_hist[n0 % 1024]), 8'h81);

      // R1 asynchronous reset in the middle of a frame
      n0 = got_n;
      fork
         send_frame(8'h77, 1'b0);
         begin
            repeat (40) @(negedge clk);
            #1 rst_n = 1'b0;
            #1;
            chk("R1 data cleared mid-frame", int'(out_data), 0);
            chk("R1 valid low mid-frame", int'(out_valid), 0);
         end
      join
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      chk("R1 no byte from reset frame", got_n - n0, 0);
      chk("R1 data zero after reset", int'(out_data), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule